// File: doc/BRIEF.md
# Shared GPIO Port with Peripheral Override

This block is a 16-pin general-purpose I/O port controller reached through a small register bus. It keeps three registers: a direction register, an output latch and an analog-select mask. For each pin it drives an output-enable and an output-data signal towards a pad. It samples the pad input through one register stage, and that sampled value is what a port read returns. Pins marked analog are hidden from the digital input path. Their read value and the value passed to the peripheral are both zero, but the output driver still obeys the direction bit.

Any pin can be handed to an on-chip peripheral. When a pin's peripheral enable is high, its output-enable and output-data come from the peripheral and no longer from the registers. The sampled pad level goes back to the peripheral on a dedicated input vector. Software that changes a pin and then reads the port must allow one extra cycle. A port read in the cycle right after the write still shows the old pin level.

The reset input is asserted asynchronously and released through a two-stage synchronizer. The registers leave reset two clock edges after `rst_n` rises.

Top module: `gpio_shared_port`

## Requirements
- R1: For a pin not taken by a peripheral, a direction bit of 1 turns the pad output-enable off (input), and a direction bit of 0 turns it on. `pad_out` always carries the latch bit for such a pin.
- R2: A write to address 1 (port) and a write to address 2 (latch) update the same output latch. The pad reflects the new value from the cycle after the write.
- R3: Bus addresses are 0 = direction, 1 = port, 2 = latch, 3 = analog mask. Reads of addresses 0, 2 and 3 return the stored register. `bus_rdata` is registered and valid in the cycle after `bus_re`, and it is zero in any cycle that follows one without `bus_re`.
- R4: A read of address 1 returns the sampled pin levels with every analog-marked pin forced to 0, whatever the pad level.
- R5: `per_in` carries the registered pad level for digital pins and 0 for every analog-marked pin.
- R6: An analog-marked pin with its direction bit at 0 still drives its latch value with the output enabled. Direction and analog selection act independently.
- R7: When `per_en[i]` is 1, `pad_oe[i]` and `pad_out[i]` equal `per_oe[i]` and `per_out[i]`, whatever the direction and latch registers hold.
- R8: A port read issued in the cycle right after a latch or direction write returns the pin state from before the write. A read one cycle later returns the new state.
- R9: After reset the direction register is all ones, the latch is all zeros, the analog mask is all ones and `bus_rdata` is zero.
- R10: When a write and a read address the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 dir, 1 port, 2 latch, 3 analog) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pad_oe | output | 16 | Per-pin pad output-enable |
| pad_out | output | 16 | Per-pin pad output data |
| pad_in | input | 16 | Per-pin pad input level |
| per_en | input | 16 | Per-pin peripheral takeover |
| per_oe | input | 16 | Peripheral output-enable |
| per_out | input | 16 | Peripheral output data |
| per_in | output | 16 | Pad level delivered to the peripheral, analog pins zeroed |

## Verification
Two functions can fall in the same cycle: a register write and a register read. This happens with the same address, as a latch write with a latch read, and with different addresses, as a latch write followed at once by a port read. The bench provokes the same-address case on purpose and expects the pre-write value. It provokes the write-then-port-read case and expects the old pin state, then the new state one read later. A long stretch of random bus, peripheral and external pad traffic then produces many more such collisions. In every cycle, a behavioural model that updates its registers, sampled pins and read data once per edge judges the pad, peripheral and read outputs.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register addresses on the port bus
  typedef enum logic [1:0] {
    GP_ADDR_DIR   = 2'd0,
    GP_ADDR_PORT  = 2'd1,
    GP_ADDR_LATCH = 2'd2,
    GP_ADDR_ANA   = 2'd3
  } gp_addr_e;

endpackage

// File: rtl/gpio_reset_sync.sv
module gpio_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] ana_q
);

  logic         dir_en;
  logic         lat_en;
  logic         ana_en;
  logic [W-1:0] dir_d;
  logic [W-1:0] lat_d;
  logic [W-1:0] ana_d;

  // Address decode: port and latch addresses share one latch
  always_comb begin
    dir_en = 1'b0;
    lat_en = 1'b0;
    ana_en = 1'b0;
    if (wr_en) begin
      unique case (gp_addr_e'(wr_addr))
        GP_ADDR_DIR:   dir_en = 1'b1;
        GP_ADDR_PORT:  lat_en = 1'b1;
        GP_ADDR_LATCH: lat_en = 1'b1;
        GP_ADDR_ANA:   ana_en = 1'b1;
        default:       ;
      endcase
    end
    dir_d = dir_en ? wr_data : dir_q;
    lat_d = lat_en ? wr_data : lat_q;
    ana_d = ana_en ? wr_data : ana_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
      ana_q <= '1;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (lat_en) lat_q <= lat_d;
      if (ana_en) ana_q <= ana_d;
    end
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int W = 16
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] per_en,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] per_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out
);

  for (genvar gi = 0; gi < W; gi++) begin : g_pin
    logic reg_oe;
    logic reg_out;

    always_comb begin
      reg_oe  = ~dir_q[gi];
      reg_out = lat_q[gi];
      if (per_en[gi]) begin
        pad_oe[gi]  = per_oe[gi];
        pad_out[gi] = per_out[gi];
      end else begin
        pad_oe[gi]  = reg_oe;
        pad_out[gi] = reg_out;
      end
    end
  end

endmodule

// File: rtl/gpio_input_sample.sv
module gpio_input_sample #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] ana_q,
  output logic [W-1:0] dig_in
);

  logic [W-1:0] pin_q;
  logic [W-1:0] pin_d;

  always_comb begin
    pin_d = pad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
    end else begin
      pin_q <= pin_d;
    end
  end

  // Analog-selected pins never reach the digital path
  for (genvar gi = 0; gi < W; gi++) begin : g_mask
    assign dig_in[gi] = pin_q[gi] & ~ana_q[gi];
  end

endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
  import gpio_port_pkg::*;
#(
  parameter int W          = 16,
  parameter int SYNC_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic         bus_re,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] per_en,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] per_out,
  output logic [W-1:0] per_in
);

  logic         rst_n_sync;
  logic [W-1:0] dir_q;
  logic [W-1:0] lat_q;
  logic [W-1:0] ana_q;
  logic [W-1:0] dig_in;
  logic [W-1:0] rd_mux;
  logic [W-1:0] rd_d;
  logic [W-1:0] rd_q;

  gpio_reset_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  gpio_port_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (bus_we),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .dir_q   (dir_q),
    .lat_q   (lat_q),
    .ana_q   (ana_q)
  );

  gpio_pin_mux #(.W(W)) u_mux (
    .dir_q   (dir_q),
    .lat_q   (lat_q),
    .per_en  (per_en),
    .per_oe  (per_oe),
    .per_out (per_out),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );

  gpio_input_sample #(.W(W)) u_samp (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .pad_in (pad_in),
    .ana_q  (ana_q),
    .dig_in (dig_in)
  );

  // Read select uses pre-write register values
  always_comb begin
    unique case (gp_addr_e'(bus_addr))
      GP_ADDR_DIR:   rd_mux = dir_q;
      GP_ADDR_PORT:  rd_mux = dig_in;
      GP_ADDR_LATCH: rd_mux = lat_q;
      GP_ADDR_ANA:   rd_mux = ana_q;
      default:       rd_mux = '0;
    endcase
    rd_d = bus_re ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign bus_rdata = rd_q;
  assign per_in    = dig_in;

endmodule

// File: rtl/gpio_shared_port_chk.sv
module gpio_shared_port_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n_int,
  input logic         bus_we,
  input logic         bus_re,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] per_en,
  input logic [W-1:0] per_in,
  input logic [W-1:0] ana_q
);

  logic live_q;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) live_q <= 1'b0;
    else            live_q <= 1'b1;
  end

  // R2: latch write visible on non-overridden pad outputs next cycle
  assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2))
      |=> (((pad_out ^ $past(bus_wdata)) & ~per_en) == '0));

  // R1: direction write sets inverted output-enable on non-overridden pins
  assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_we && bus_addr == 2'd0)
      |=> (((pad_oe ^ ~$past(bus_wdata)) & ~per_en) == '0));

  // R4: analog pins read as zero on a port read
  assert_analog_zero_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_re && bus_addr == 2'd1) |=> ((bus_rdata & $past(ana_q)) == '0));

  // R3: no read strobe gives zero read data
  assert_idle_read_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    !bus_re |=> (bus_rdata == '0));

  // R5: peripheral input is last cycle's pad level on digital pins
  assert_per_in_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    live_q |-> ((per_in ^ ($past(pad_in) & ~ana_q)) == '0));

endmodule

bind gpio_shared_port gpio_shared_port_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n_int (rst_n_sync),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_in    (pad_in),
  .per_en    (per_en),
  .per_in    (per_in),
  .ana_q     (ana_q)
);

// File: tb/test_gpio_shared_port.sv
module test_gpio_shared_port;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic         bus_re = 1'b0;
  logic [1:0]   bus_addr = 2'd0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pad_oe;
  logic [W-1:0] pad_out;
  logic [W-1:0] pad_in;
  logic [W-1:0] per_en = '0;
  logic [W-1:0] per_oe = '0;
  logic [W-1:0] per_out = '0;
  logic [W-1:0] per_in;
  logic [W-1:0] ext_val = '0;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  // Pad resolution: driven pins loop back, others follow the external level
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_val);

  gpio_shared_port i_gpio_shared_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_in    (pad_in),
    .per_en    (per_en),
    .per_oe    (per_oe),
    .per_out   (per_out),
    .per_in    (per_in)
  );

  // ---------------- reference model ----------------
  logic [W-1:0] m_dir, m_lat, m_ana, m_pins, m_rd;
  logic [W-1:0] e_oe, e_out, e_pin, e_per_in;
  int           m_live;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (per_en[i]) begin
        e_oe[i]  = per_oe[i];
        e_out[i] = per_out[i];
      end else begin
        e_oe[i]  = !m_dir[i];
        e_out[i] = m_lat[i];
      end
      e_pin[i]    = e_oe[i] ? e_out[i] : ext_val[i];
      e_per_in[i] = m_ana[i] ? 1'b0 : m_pins[i];
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live <= 0;
      m_dir  <= '1;
      m_lat  <= '0;
      m_ana  <= '1;
      m_pins <= '0;
      m_rd   <= '0;
    end else if (m_live < 2) begin
      m_live <= m_live + 1;
      m_dir  <= '1;
      m_lat  <= '0;
      m_ana  <= '1;
      m_pins <= '0;
      m_rd   <= '0;
    end else begin
      m_pins <= e_pin;
      if (!bus_re)                m_rd <= '0;
      else if (bus_addr == 2'd0)  m_rd <= m_dir;
      else if (bus_addr == 2'd1)  m_rd <= e_per_in;
      else if (bus_addr == 2'd2)  m_rd <= m_lat;
      else                        m_rd <= m_ana;
      if (bus_we) begin
        if (bus_addr == 2'd0)      m_dir <= bus_wdata;
        else if (bus_addr == 2'd3) m_ana <= bus_wdata;
        else                       m_lat <= bus_wdata;
      end
    end
  end

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R1/R6/R7 model pad_oe", pad_oe, e_oe);
      check("R2/R7 model pad_out", pad_out, e_out);
      check("R5 model per_in", per_in, e_per_in);
      check("R3/R4/R8/R10 model rdata", bus_rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic bus_write(logic [1:0] a, logic [W-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, logic [W-1:0] exp, string tag);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
    #1;
    bus_re = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(posedge clk);
    cmp_on = 1'b1;
    repeat (2) tick();
    check("R9 rdata in reset", bus_rdata, 16'h0000);
    check("R9 pad_oe in reset", pad_oe, 16'h0000);
    rst_n = 1'b1;
    repeat (4) tick();

    // R9 reset values
    bus_read(2'd0, 16'hFFFF, "R9 dir reset");
    bus_read(2'd2, 16'h0000, "R9 latch reset");
    bus_read(2'd3, 16'hFFFF, "R9 analog reset");
    bus_read(2'd1, 16'h0000, "R9 port reset");

    // R1/R2: low byte outputs, write latch through port address
    ext_val = 16'h3C00;
    bus_write(2'd3, 16'h0000);
    bus_write(2'd0, 16'hFF00);
    bus_write(2'd1, 16'h00A5);
    check("R1 pad_oe", pad_oe, 16'h00FF);
    check("R2 pad_out after port write", pad_out, 16'h00A5);
    bus_read(2'd2, 16'h00A5, "R2 latch via port address");
    tick();
    bus_read(2'd1, 16'h3CA5, "R1 port levels");

    // R8: read right after write sees old state
    bus_write(2'd2, 16'h005A);
    bus_read(2'd1, 16'h3CA5, "R8 old state");
    bus_read(2'd1, 16'h3C5A, "R8 new state");

    // R4/R5/R6: analog mask
    bus_write(2'd3, 16'h0F0F);
    tick();
    bus_read(2'd1, 16'h3050, "R4 analog pins zero");
    check("R5 per_in analog zero", per_in, 16'h3050);
    check("R6 analog pins still enabled", pad_oe, 16'h00FF);
    check("R6 analog pins still driven", pad_out, 16'h005A);

    // R7: peripheral override on pins 15 and 0
    per_en = 16'h8001; per_oe = 16'h8000; per_out = 16'h8001;
    #1;
    check("R7 override oe", pad_oe, 16'h80FE);
    check("R7 override out", pad_out, 16'h805B);
    repeat (2) tick();
    check("R7 peripheral drives pin 15", per_in & 16'h8000, 16'h8000);
    per_en = '0; per_oe = '0; per_out = '0;
    tick();

    // R10: write and read of latch in one cycle
    bus_we = 1'b1; bus_re = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h1234;
    @(negedge clk);
    check("R10 read returns pre-write value", bus_rdata, 16'h005A);
    #1;
    bus_we = 1'b0;
    @(negedge clk);
    check("R10 next read sees write", bus_rdata, 16'h1234);
    #1;
    bus_re = 1'b0;

    // R3: readback of direction and mask, idle data
    bus_read(2'd0, 16'hFF00, "R3 dir readback");
    bus_read(2'd3, 16'h0F0F, "R3 analog readback");
    tick();
    check("R3 idle rdata zero", bus_rdata, 16'h0000);

    // Random traffic judged by the model every cycle
    for (int n = 0; n < 3000; n++) begin
      bus_we    = ($urandom % 3) == 0;
      bus_re    = ($urandom % 2) == 0;
      bus_addr  = 2'($urandom % 4);
      bus_wdata = 16'($urandom);
      per_en    = 16'($urandom) & 16'($urandom);
      per_oe    = 16'($urandom);
      per_out   = 16'($urandom);
      ext_val   = 16'($urandom);
      tick();
    end
    bus_we = 1'b0; bus_re = 1'b0; per_en = '0;

    // R9: reset mid-run
    rst_n = 1'b0;
    repeat (2) tick();
    check("R9 rdata after mid reset", bus_rdata, 16'h0000);
    check("R9 pad_oe after mid reset", pad_oe, 16'h0000);
    rst_n = 1'b1;
    repeat (4) tick();
    bus_read(2'd0, 16'hFFFF, "R9 dir after mid reset");
    bus_read(2'd3, 16'hFFFF, "R9 analog after mid reset");
    bus_read(2'd2, 16'h0000, "R9 latch after mid reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule